// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Command Controller

This block is the command-side power-state logic of a serial flash slave on an SPI mode 0 bus. The chip-select, serial clock and serial data lines are oversampled on the system clock. Instruction bits enter MSB first on each rising edge of the serial clock while chip-select is low. A falling chip-select starts a new frame. A chip-select that rises part way through an instruction throws that instruction away.

The power-down instruction (0xB9) is committed only if chip-select rises after exactly eight bits have been latched, and only while no write, program or erase cycle is running. A fixed delay of `T_DP` system clocks then passes before the low-power state begins. In the low-power state the block decodes only the wake/signature instruction (0xAB), and every other instruction is dropped. When chip-select rises after a decoded 0xAB, the block leaves the low-power state and waits `T_RES` clocks before it decodes anything again. In any state where 0xAB is decoded, three dummy bytes follow the opcode. After them the block shifts out the `SIG` byte repeatedly on SO.

Top module: `dpd_ctrl`

## Requirements
- R1: After reset the block is in standby: `dp_status`, `cmd_accept` and `so` are all 0.
- R2: Opcode bits are shifted MSB first on SCK rising edges while `cs_n` is low, and a falling `cs_n` restarts the bit count. In standby any opcode is decoded, with one exception: 0xB9 is not decoded while `busy` is high. `cmd_accept` is a single-clock pulse on the clock after the eighth SCK rising edge, and it appears only for a decoded opcode.
- R3: 0xB9 commits only when `cs_n` rises with exactly 8 bits latched in the frame. A frame of 7 or 9 bits leaves the block in standby.
- R4: `T_DP` clocks after the commit edge, `dp_status` goes to 1. It stays 0 during the delay, and no opcode is decoded during the delay.
- R5: 0xB9 is rejected while `busy` is high. It gives no `cmd_accept` and the block stays in standby.
- R6: In the low-power state every opcode other than 0xAB is ignored, including 0x06, 0x02, 0xD8 and 0xB9. There is no `cmd_accept` and `dp_status` stays 1.
- R7: When `cs_n` rises after a decoded 0xAB in the low-power state, `dp_status` falls on the next clock. For `T_RES` clocks after that, nothing is decoded. After those clocks, standby decoding resumes.
- R8: After a decoded 0xAB and 24 more bits, SO presents `SIG` MSB first, changing on SCK falling edges. The byte repeats while `cs_n` stays low. SO is 0 whenever `cs_n` is high.
- R9: A 0xAB frame that ends before its eighth bit leaves the block in the low-power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data in |
| busy | input | 1 | High while a write/program/erase cycle runs |
| so | output | 1 | Serial data out (signature) |
| dp_status | output | 1 | High only in the low-power state |
| cmd_accept | output | 1 | One-clock pulse when an opcode is decoded |

## Verification
The power-down opcode is sent with 7, 8 and 9 bits. This separates a decoder that commits on the bit count from one that commits on the opcode value alone. The opcode is also sent with `busy` high, and the delay edge is checked on the exact clock on which it falls. In the low-power state, several write-class opcodes, a repeated power-down and a truncated wake frame are sent; these tell real filtering apart from plain decoding. Wake frames are sent with and without a signature read, and one frame is sent inside the `T_RES` window. These show the release timing and that the signature byte wraps over two bytes.

// File: rtl/dpd_ctrl.sv
module dpd_ctrl #(
  parameter int          T_DP  = 16,
  parameter int          T_RES = 12,
  parameter logic [7:0]  SIG   = 8'h12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic busy,
  output logic so,
  output logic dp_status,
  output logic cmd_accept
);
  localparam logic [7:0] OP_DOWN = 8'hB9;
  localparam logic [7:0] OP_WAKE = 8'hAB;
  localparam int TMAX = (T_DP > T_RES) ? T_DP : T_RES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [5:0] HDR = 6'd32;

  typedef enum logic [1:0] {ST_IDLE, ST_ENTER, ST_DEEP, ST_LEAVE} st_t;
  st_t st;

  logic          sck_q, cs_q, rd, dn_ok, decode_ok;
  logic [5:0]    nbits;
  logic [7:0]    sh;
  logic [2:0]    sidx;
  logic [TW-1:0] tmr;

  wire sck_up = sck & ~sck_q & ~cs_n;
  wire sck_dn = ~sck & sck_q & ~cs_n;
  wire cs_up  = cs_n & ~cs_q;
  wire cs_dn  = ~cs_n & cs_q;
  wire [7:0] nxt_byte = {sh[6:0], si};

  always_comb
    case (st)
      ST_IDLE: decode_ok = (nxt_byte != OP_DOWN) || !busy;
      ST_DEEP: decode_ok = (nxt_byte == OP_WAKE);
      default: decode_ok = 1'b0;
    endcase

  assign dp_status = (st == ST_DEEP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; nbits <= '0; sh <= '0;
      rd <= 1'b0; dn_ok <= 1'b0; sidx <= '0; so <= 1'b0; cmd_accept <= 1'b0;
    end else begin
      sck_q      <= sck;
      cs_q       <= cs_n;
      cmd_accept <= 1'b0;
      if (cs_dn) begin
        nbits <= '0; rd <= 1'b0; dn_ok <= 1'b0; sidx <= '0;
      end else if (sck_up) begin
        sh <= nxt_byte;
        if (nbits < HDR) nbits <= nbits + 6'd1;
        if (nbits == 6'd7) begin
          cmd_accept <= decode_ok;
          rd         <= decode_ok && (nxt_byte == OP_WAKE);
          dn_ok      <= decode_ok && (nxt_byte == OP_DOWN);
        end
      end
      if (cs_n) so <= 1'b0;
      else if (sck_dn && rd && nbits == HDR) begin
        so   <= SIG[3'd7 - sidx];
        sidx <= sidx + 3'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; tmr <= '0;
    end else
      case (st)
        ST_IDLE:  if (cs_up && nbits == 6'd8 && dn_ok && !busy) begin st <= ST_ENTER; tmr <= '0; end
        ST_ENTER: if (tmr == TW'(T_DP - 1)) st <= ST_DEEP; else tmr <= tmr + 1'b1;
        ST_DEEP:  if (cs_up && rd) begin st <= ST_LEAVE; tmr <= '0; end
        ST_LEAVE: if (tmr == TW'(T_RES - 1)) st <= ST_IDLE; else tmr <= tmr + 1'b1;
        default:  st <= ST_IDLE;
      endcase

  AST_DP_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_status) |-> $past(st) == ST_ENTER); // R4
  AST_NO_DECODE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> ($past(st) == ST_IDLE || $past(st) == ST_DEEP)); // R7
  AST_DEEP_ONLY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && $past(st) == ST_DEEP) |-> rd); // R6
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ENTER && $past(st) == ST_IDLE) |-> !$past(busy)); // R5
  AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !so); // R8
  AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !cmd_accept); // R2
endmodule

// File: tb/dpd_ctrl_tb_top.sv
module dpd_ctrl_tb_top;
  localparam int T_DP = 20;
  localparam int T_RES = 60;
  localparam logic [7:0] SIG = 8'hC5;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, busy = 0;
  logic so, dp_status, cmd_accept;
  int checks = 0, errors = 0, acc_n = 0;
  bit mon_en = 0, done = 0;

  always #4 clk = ~clk;

  dpd_ctrl #(.T_DP(T_DP), .T_RES(T_RES), .SIG(SIG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
    .so(so), .dp_status(dp_status), .cmd_accept(cmd_accept));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model: mode 0 standby, 1 entering, 2 deep, 3 leaving
  int m_st, m_old, m_cnt, m_bits, m_sidx;
  logic [7:0] m_byte;
  logic m_rd, m_down, m_so, m_acc, p_sck, p_cs, e_up, e_dn, e_csu, e_csd, ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_bits = 0; m_sidx = 0; m_byte = 0;
      m_rd = 0; m_down = 0; m_so = 0; m_acc = 0; p_sck = 0; p_cs = 1;
    end else begin
      e_up = sck && !p_sck && !cs_n;  e_dn = !sck && p_sck && !cs_n;
      e_csu = cs_n && !p_cs;          e_csd = !cs_n && p_cs;
      m_acc = 0; m_old = m_st;
      if (m_st == 1) begin if (m_cnt == T_DP - 1) m_st = 2; else m_cnt++; end
      else if (m_st == 3) begin if (m_cnt == T_RES - 1) m_st = 0; else m_cnt++; end
      else if (m_st == 0 && e_csu && m_bits == 8 && m_down && !busy) begin m_st = 1; m_cnt = 0; end
      else if (m_st == 2 && e_csu && m_rd) begin m_st = 3; m_cnt = 0; end
      if (e_csd) begin m_bits = 0; m_rd = 0; m_down = 0; m_sidx = 0; end
      else if (e_up) begin
        m_byte = {m_byte[6:0], si};
        if (m_bits < 32) m_bits++;
        if (m_bits == 8) begin
          ok = (m_old == 0 && (m_byte != 8'hB9 || !busy)) || (m_old == 2 && m_byte == 8'hAB);
          m_acc = ok; m_rd = ok && m_byte == 8'hAB; m_down = ok && m_byte == 8'hB9;
        end
      end
      if (cs_n) m_so = 0;
      else if (e_dn && m_rd && m_bits == 32) begin m_so = SIG[7 - m_sidx]; m_sidx = (m_sidx + 1) % 8; end
      p_sck = sck; p_cs = cs_n;
    end
  end

  always @(negedge clk) begin
    if (cmd_accept) acc_n++;
    if (mon_en) begin
      chk("R4 model dp_status", 64'(dp_status), 64'(m_st == 2));
      chk("R2 model cmd_accept", 64'(cmd_accept), 64'(m_acc));
      chk("R8 model so", 64'(so), 64'(m_so));
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send opc followed by zeros, nb bits total; cs_n left high on return
  task automatic frame(input logic [7:0] opc, input int nb, output logic [63:0] got);
    got = '0;
    @(negedge clk); cs_n = 0; clks(2);
    for (int i = 0; i < nb; i++) begin
      sck = 0; si = (i < 8) ? opc[7 - i] : 1'b0; clks(2);
      sck = 1;
      if (i >= 32) got = {got[62:0], so};
      clks(2);
    end
    sck = 0; clks(2);
    cs_n = 1;
  endtask

  logic [63:0] g;

  initial begin
    clks(3);
    chk("R1 dp_status", 64'(dp_status), 0);
    chk("R1 so", 64'(so), 0);
    chk("R1 cmd_accept", 64'(cmd_accept), 0);
    rst_n = 1; mon_en = 1; clks(2);

    acc_n = 0; frame(8'h06, 8, g); clks(4);
    chk("R2 accept in standby", 64'(acc_n), 1);

    acc_n = 0; frame(8'hB9, 7, g); clks(T_DP + 5);
    chk("R3 seven bits", 64'(dp_status), 0);
    chk("R3 seven bits no accept", 64'(acc_n), 0);
    frame(8'hB9, 9, g); clks(T_DP + 5);
    chk("R3 nine bits", 64'(dp_status), 0);

    busy = 1; acc_n = 0; frame(8'hB9, 8, g); clks(T_DP + 5);
    chk("R5 busy no accept", 64'(acc_n), 0);
    chk("R5 busy stays standby", 64'(dp_status), 0);
    busy = 0;

    frame(8'hB9, 8, g); clks(T_DP);
    chk("R4 low during delay", 64'(dp_status), 0);
    clks(1);
    chk("R4 high after delay", 64'(dp_status), 1);

    acc_n = 0;
    frame(8'h06, 8, g); clks(2);
    frame(8'h02, 8, g); clks(2);
    frame(8'hD8, 8, g); clks(2);
    frame(8'hB9, 8, g); clks(T_DP + 3);
    chk("R6 no accept in deep", 64'(acc_n), 0);
    chk("R6 still deep", 64'(dp_status), 1);

    frame(8'hAB, 5, g); clks(4);
    chk("R9 short wake", 64'(dp_status), 1);

    acc_n = 0; frame(8'hAB, 8, g);
    chk("R7 wake decoded", 64'(acc_n), 1);
    clks(1);
    chk("R7 leaves deep", 64'(dp_status), 0);
    acc_n = 0; frame(8'h06, 8, g); clks(2);
    chk("R7 ignored in wait", 64'(acc_n), 0);
    clks(T_RES);
    acc_n = 0; frame(8'h06, 8, g); clks(2);
    chk("R7 standby resumes", 64'(acc_n), 1);

    frame(8'hAB, 48, g); clks(2);
    chk("R8 signature standby", g[15:0], {SIG, SIG});
    chk("R8 so idle", 64'(so), 0);

    frame(8'hB9, 8, g); clks(T_DP + 3);
    chk("R4 deep again", 64'(dp_status), 1);
    frame(8'hAB, 40, g); clks(2);
    chk("R8 signature on wake", g[7:0], SIG);
    chk("R7 woke after read", 64'(dp_status), 0);
    clks(T_RES + 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule